// File: doc/BRIEF.md
# Stacked Layer-2 Header Walker

This block watches a received Ethernet frame one byte per clock and walks its layer-2 header without buffering the frame. It captures the destination and source station addresses, the first ethertype after the addresses, the last ethertype it accepted, and the control field of the outermost VLAN tag. It follows stacked VLAN tags, LLC/SNAP and jumbo/SNAP encapsulation, MPLS label stacks and PPPoE session headers. The walk ends on a terminal protocol (IPv4, IPv6, ARP) or on a type that the current header may not carry.

At the end of the walk the block raises a one-cycle `done` strobe. With it come a protocol code for the layer-3 header and that header's byte offset from the start of the frame. A frame that ends before the walk finishes still produces the strobe, with the truncation flag set. Bytes after the walk has finished are ignored until the next start-of-frame.

Top module: `l2p_hdr_walker`

## Requirements
- R1: After reset every output is zero and `done` is low.
- R2: A frame whose start byte arrives with `cfg_depth` equal to zero is ignored: no `done` pulse follows and all outputs keep their values.
- R3: Frame bytes 0-5 give `dst_mac` and bytes 6-11 give `src_mac`, the earliest byte in the most significant position. Bytes 12-13 give `first_type`, high byte first.
- R4: Type 0x0800 ends the walk with `l3_kind` 1, 0x86DD with 2 and 0x0806 with 3. `l3_off` is the index of the byte after that type field, and `done` is high for exactly one cycle, in the cycle after the clock edge that takes the last header byte.
- R5: Type 0x8100 is followed by a 2-byte control field and then another type, which may be any supported type. `vlan_tci` keeps the outermost tag's control field and `vlan_hit` goes to 1.
- R6: A type value of 1500 or less is a length, and 0x8870 is jumbo. Either is followed by a 3-byte LLC header. If the first two LLC bytes are 0xAA 0xAA, a 3-byte OUI and another type follow. Any other LLC header ends the walk with `l3_kind` 4 and `l3_off` just after the LLC header.
- R7: After SNAP, a length value or 0x8870 is not allowed and stops the walk as in R8.
- R8: A type that is not allowed at that point ends the walk with `l3_kind` 4 and `l3_off` at the first byte of the rejected type field. The rejected value is not recorded.
- R9: Type 0x8847 or 0x8848 starts a stack of 4-byte labels, which ends at the label whose third byte has bit 0 set. The high nibble of the next byte selects `l3_kind`: 4 gives 1, 6 gives 2, anything else gives 4. `l3_off` is that byte's index.
- R10: Type 0x8864 is followed by a 6-byte session header and a 2-byte protocol. 0x0021 gives IPv4, 0x0057 gives IPv6, and any other value gives `l3_kind` 4, each with `l3_off` after the protocol. 0x0281 or 0x0283 continues into an MPLS stack as in R9 and leaves `last_type` unchanged.
- R11: If the end-of-frame byte arrives before the walk ends, `done` still pulses, with `trunc` 1, `l3_kind` 0 and `l3_off` equal to the frame length.
- R12: A start byte always restarts the walk, even mid-frame. Bytes after the walk ends do not produce another `done`, and `l3_kind`, `l3_off` and `trunc` change only with `done`.
- R13: `last_type` holds the last type or length field that was accepted. It is cleared at each enabled start byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_depth | input | DEPTH_W | Walk enable, sampled on the start byte (zero disables) |
| in_valid | input | 1 | Byte strobe |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_data | input | 8 | Frame byte |
| dst_mac | output | 48 | Destination station address |
| src_mac | output | 48 | Source station address |
| first_type | output | 16 | Type or length at bytes 12-13 |
| last_type | output | 16 | Last accepted type or length |
| vlan_tci | output | 16 | Outermost VLAN control field |
| vlan_hit | output | 1 | A VLAN tag was seen |
| l3_kind | output | 3 | 0 none, 1 IPv4, 2 IPv6, 3 ARP, 4 unknown |
| l3_off | output | OFF_W | Byte offset of the layer-3 header |
| trunc | output | 1 | Frame ended before the walk finished |
| done | output | 1 | One-cycle result strobe |

## Verification
A wrong header mode or wrong remaining-byte count puts every later field boundary out of step. The effect reaches the ports at that frame's `done`: a shifted `l3_off`, a wrong `l3_kind`, or a `done` that arrives early, late or twice. A wrong context register shows up as a transition that is accepted or refused against the allowed-transition rules, for example a second SNAP or an LLC header after SNAP. Because each frame is compared field by field at its strobe, a fault surfaces within the frame that triggers it.

// File: rtl/l2p_pkg.sv
package l2p_pkg;
  typedef enum logic [2:0] {
    L3_NONE = 3'd0, L3_IPV4 = 3'd1, L3_IPV6 = 3'd2, L3_ARP = 3'd3, L3_UNKNOWN = 3'd4
  } l3_kind_e;

  typedef enum logic [1:0] {CTX_ETH, CTX_VLAN, CTX_SNAP} ctx_e;

  typedef enum logic [3:0] {
    ACT_STOP, ACT_IPV4, ACT_IPV6, ACT_ARP, ACT_VLAN, ACT_LLC, ACT_JUMBO, ACT_MPLS, ACT_PPPOE
  } act_e;

  typedef enum logic [3:0] {
    M_IDLE, M_MAC, M_TYPE, M_TCI, M_LLC, M_OUI, M_MPLS, M_NIB, M_PPP, M_SKIP
  } mode_e;

  localparam logic [15:0] TY_IPV4  = 16'h0800;
  localparam logic [15:0] TY_IPV6  = 16'h86DD;
  localparam logic [15:0] TY_ARP   = 16'h0806;
  localparam logic [15:0] TY_VLAN  = 16'h8100;
  localparam logic [15:0] TY_MPLSU = 16'h8847;
  localparam logic [15:0] TY_MPLSM = 16'h8848;
  localparam logic [15:0] TY_PPPOE = 16'h8864;
  localparam logic [15:0] TY_JUMBO = 16'h8870;
endpackage

// File: rtl/l2p_byte_window.sv
module l2p_byte_window #(
  parameter int BYTE_W = 8,
  parameter int SPAN   = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valid,
  input  logic [BYTE_W-1:0]        din,
  output logic [SPAN*BYTE_W-1:0]   win
);
  logic [BYTE_W-1:0] stage_q [SPAN-1];

  assign win[BYTE_W-1:0] = din;

  for (genvar g = 0; g < SPAN-1; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)        stage_q[g] <= '0;
      else if (valid) stage_q[g] <= (g == 0) ? din : stage_q[(g == 0) ? 0 : g-1];
    end
    assign win[(g+1)*BYTE_W +: BYTE_W] = stage_q[g];
  end
endmodule

// File: rtl/l2p_type_judge.sv
module l2p_type_judge import l2p_pkg::*; #(
  parameter int LLC_MAX = 1500
) (
  input  ctx_e        ctx,
  input  logic [15:0] ty,
  output act_e        act
);
  always_comb begin
    act = ACT_STOP;
    if (ty == TY_IPV4)                             act = ACT_IPV4;
    else if (ty == TY_IPV6)                        act = ACT_IPV6;
    else if (ty == TY_ARP)                         act = ACT_ARP;
    else if (ty == TY_VLAN)                        act = ACT_VLAN;
    else if (ty == TY_MPLSU || ty == TY_MPLSM)     act = ACT_MPLS;
    else if (ty == TY_PPPOE)                       act = ACT_PPPOE;
    else if (ctx != CTX_SNAP) begin
      if (32'(ty) <= LLC_MAX)                      act = ACT_LLC;
      else if (ty == TY_JUMBO)                     act = ACT_JUMBO;
    end
  end
endmodule

// File: rtl/l2p_hdr_walker.sv
module l2p_hdr_walker import l2p_pkg::*; #(
  parameter int DEPTH_W = 4,
  parameter int OFF_W   = 8,
  parameter int LLC_MAX = 1500
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DEPTH_W-1:0] cfg_depth,
  input  logic               in_valid,
  input  logic               in_sof,
  input  logic               in_eof,
  input  logic [7:0]         in_data,
  output logic [47:0]        dst_mac,
  output logic [47:0]        src_mac,
  output logic [15:0]        first_type,
  output logic [15:0]        last_type,
  output logic [15:0]        vlan_tci,
  output logic               vlan_hit,
  output logic [2:0]         l3_kind,
  output logic [OFF_W-1:0]   l3_off,
  output logic               trunc,
  output logic               done
);
  localparam int BYTE_W    = 8;
  localparam int SPAN      = 3;
  localparam int MAC_BYTES = 12;
  localparam int CNT_W     = $clog2(MAC_BYTES);

  mode_e              mode_q, cur_mode, nx_mode;
  ctx_e               ctx_q, nx_ctx;
  logic [CNT_W-1:0]   cnt_q, cur_cnt, nx_cnt;
  logic [OFF_W-1:0]   pos_q, cur_pos, fin_off;
  logic [95:0]        mac_q;
  logic [15:0]        first_q, last_q, tci_q;
  logic               vhit_q, done_q, trunc_q;
  l3_kind_e           kind_q, fin_kind;
  logic [OFF_W-1:0]   off_q;
  logic [SPAN*BYTE_W-1:0] win;
  act_e               act;
  logic start, active, last_b, fin, trunc_now, take_type, take_first, take_tci;

  l2p_byte_window #(.BYTE_W(BYTE_W), .SPAN(SPAN)) u_win (
    .clk(clk), .rst(rst), .valid(in_valid), .din(in_data), .win(win)
  );

  l2p_type_judge #(.LLC_MAX(LLC_MAX)) u_judge (
    .ctx(ctx_q), .ty(win[15:0]), .act(act)
  );

  always_comb begin
    start    = in_valid && in_sof;
    cur_mode = start ? ((cfg_depth != '0) ? M_MAC : M_IDLE) : mode_q;
    cur_cnt  = start ? CNT_W'(MAC_BYTES-1) : cnt_q;
    cur_pos  = start ? '0 : pos_q;
    active   = in_valid && cur_mode != M_IDLE && cur_mode != M_SKIP;
    last_b   = (cur_cnt == '0);
    nx_mode  = cur_mode;
    nx_cnt   = CNT_W'(cur_cnt - 1'b1);
    nx_ctx   = ctx_q;
    fin = 1'b0; trunc_now = 1'b0; fin_kind = L3_NONE;
    fin_off = OFF_W'(cur_pos + 1'b1);
    take_type = 1'b0; take_first = 1'b0; take_tci = 1'b0;
    if (active && last_b) begin
      case (cur_mode)
        M_MAC: begin nx_mode = M_TYPE; nx_cnt = CNT_W'(1); nx_ctx = CTX_ETH; end
        M_TYPE: begin
          take_first = (ctx_q == CTX_ETH);
          take_type  = (act != ACT_STOP);
          case (act)
            ACT_IPV4:  begin fin = 1'b1; fin_kind = L3_IPV4; end
            ACT_IPV6:  begin fin = 1'b1; fin_kind = L3_IPV6; end
            ACT_ARP:   begin fin = 1'b1; fin_kind = L3_ARP; end
            ACT_VLAN:  begin nx_mode = M_TCI;  nx_cnt = CNT_W'(1); end
            ACT_LLC, ACT_JUMBO: begin nx_mode = M_LLC; nx_cnt = CNT_W'(2); end
            ACT_MPLS:  begin nx_mode = M_MPLS; nx_cnt = CNT_W'(3); end
            ACT_PPPOE: begin nx_mode = M_PPP;  nx_cnt = CNT_W'(7); end
            default: begin
              fin = 1'b1; fin_kind = L3_UNKNOWN; fin_off = OFF_W'(cur_pos - 1'b1);
            end
          endcase
        end
        M_TCI: begin
          take_tci = 1'b1; nx_mode = M_TYPE; nx_cnt = CNT_W'(1); nx_ctx = CTX_VLAN;
        end
        M_LLC: begin
          if (win[23:8] == 16'hAAAA) begin nx_mode = M_OUI; nx_cnt = CNT_W'(2); end
          else begin fin = 1'b1; fin_kind = L3_UNKNOWN; end
        end
        M_OUI: begin nx_mode = M_TYPE; nx_cnt = CNT_W'(1); nx_ctx = CTX_SNAP; end
        M_MPLS: begin
          if (win[8]) begin nx_mode = M_NIB; nx_cnt = '0; end
          else        nx_cnt = CNT_W'(3);
        end
        M_NIB: begin
          fin = 1'b1; fin_off = cur_pos;
          fin_kind = (win[7:4] == 4'h4) ? L3_IPV4 :
                     (win[7:4] == 4'h6) ? L3_IPV6 : L3_UNKNOWN;
        end
        M_PPP: begin
          case (win[15:0])
            16'h0021: begin fin = 1'b1; fin_kind = L3_IPV4; end
            16'h0057: begin fin = 1'b1; fin_kind = L3_IPV6; end
            16'h0281, 16'h0283: begin nx_mode = M_MPLS; nx_cnt = CNT_W'(3); end
            default:  begin fin = 1'b1; fin_kind = L3_UNKNOWN; end
          endcase
        end
        default: ;
      endcase
    end
    if (fin) nx_mode = M_SKIP;
    else if (active && in_eof) begin trunc_now = 1'b1; nx_mode = M_IDLE; end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_IDLE; ctx_q <= CTX_ETH; cnt_q <= '0; pos_q <= '0;
      mac_q <= '0; first_q <= '0; last_q <= '0; tci_q <= '0; vhit_q <= 1'b0;
      done_q <= 1'b0; trunc_q <= 1'b0; kind_q <= L3_NONE; off_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start || active) begin
        mode_q <= nx_mode; cnt_q <= nx_cnt; ctx_q <= nx_ctx;
      end
      if (active) pos_q <= OFF_W'(cur_pos + 1'b1);
      if (start && cfg_depth != '0) begin
        first_q <= '0; last_q <= '0; tci_q <= '0; vhit_q <= 1'b0;
      end
      if (active && cur_mode == M_MAC) mac_q <= {mac_q[87:0], in_data};
      if (take_first) first_q <= win[15:0];
      if (take_type)  last_q  <= win[15:0];
      if (take_tci && !vhit_q) begin tci_q <= win[15:0]; vhit_q <= 1'b1; end
      if (fin || trunc_now) begin
        done_q  <= 1'b1;
        kind_q  <= fin ? fin_kind : L3_NONE;
        off_q   <= fin ? fin_off : OFF_W'(cur_pos + 1'b1);
        trunc_q <= trunc_now;
      end
    end
  end

  assign dst_mac    = mac_q[95:48];
  assign src_mac    = mac_q[47:0];
  assign first_type = first_q;
  assign last_type  = last_q;
  assign vlan_tci   = tci_q;
  assign vlan_hit   = vhit_q;
  assign l3_kind    = kind_q;
  assign l3_off     = off_q;
  assign trunc      = trunc_q;
  assign done       = done_q;
endmodule

// File: rtl/l2p_hdr_walker_chk.sv
module l2p_hdr_walker_chk #(
  parameter int DEPTH_W = 4,
  parameter int OFF_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [DEPTH_W-1:0] cfg_depth,
  input logic               in_valid,
  input logic               in_sof,
  input logic [15:0]        last_type,
  input logic [2:0]         l3_kind,
  input logic [OFF_W-1:0]   l3_off,
  input logic               trunc,
  input logic               done
);
  // R4: the result strobe lasts one cycle
  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: a truncated result carries no protocol
  p_trunc_kind_r11: assert property (@(posedge clk) disable iff (rst)
    (done && trunc) |-> (l3_kind == 3'd0));

  // R2: a disabled start byte yields no strobe
  p_disabled_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof && cfg_depth == '0) |=> !done);

  // R12: result fields move only with the strobe
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(l3_kind) && $stable(l3_off) && $stable(trunc)));

  // R13: an ARP result implies the last accepted type was ARP
  p_arp_last_r13: assert property (@(posedge clk) disable iff (rst)
    (done && l3_kind == 3'd3) |-> (last_type == 16'h0806));
endmodule

bind l2p_hdr_walker l2p_hdr_walker_chk #(.DEPTH_W(DEPTH_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_depth(cfg_depth), .in_valid(in_valid), .in_sof(in_sof),
  .last_type(last_type), .l3_kind(l3_kind), .l3_off(l3_off), .trunc(trunc), .done(done)
);

// File: tb/l2p_hdr_walker_test.sv
`timescale 1ns/1ps
module l2p_hdr_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_depth = 4'd1;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic [47:0] dst_mac, src_mac;
  logic [15:0] first_type, last_type, vlan_tci;
  logic        vlan_hit, trunc, done;
  logic [2:0]  l3_kind;
  logic [7:0]  l3_off;

  always #2.5 clk = ~clk;

  l2p_hdr_walker uut (
    .clk(clk), .rst(rst), .cfg_depth(cfg_depth), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .dst_mac(dst_mac), .src_mac(src_mac),
    .first_type(first_type), .last_type(last_type), .vlan_tci(vlan_tci),
    .vlan_hit(vlan_hit), .l3_kind(l3_kind), .l3_off(l3_off), .trunc(trunc), .done(done)
  );

  typedef struct packed {
    logic [2:0]  kind;
    logic [7:0]  off;
    logic        tr;
    logic [47:0] dst;
    logic [47:0] src;
    logic [15:0] ft;
    logic [15:0] lt;
    logic [15:0] tci;
    logic        vh;
  } exp_t;

  exp_t   exp_q[$];
  string  tag_q[$];
  logic [7:0] fr[$];
  int n_cmp = 0, n_bad = 0, n_done = 0;
  bit finished = 1'b0;

  localparam logic [47:0] DA = 48'h0011_2233_4455;
  localparam logic [47:0] SA = 48'h6677_8899_AABB;
  localparam logic [47:0] DB = 48'hA1A2_A3A4_A5A6;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic hdr(logic [47:0] d);
    fr.delete();
    for (int i = 5; i >= 0; i--) fr.push_back(d[i*8 +: 8]);
    for (int i = 5; i >= 0; i--) fr.push_back(SA[i*8 +: 8]);
  endtask
  task automatic p16(logic [15:0] v); fr.push_back(v[15:8]); fr.push_back(v[7:0]); endtask
  task automatic p8(logic [7:0] v); fr.push_back(v); endtask

  task automatic expect_res(string tag, logic [47:0] d, logic [2:0] kind, logic [7:0] off,
                            logic tr, logic [15:0] ft, logic [15:0] lt,
                            logic [15:0] tci, logic vh);
    exp_t e;
    e.kind = kind; e.off = off; e.tr = tr; e.dst = d; e.src = SA;
    e.ft = ft; e.lt = lt; e.tci = tci; e.vh = vh;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic send(int nbytes, bit with_eof);
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = with_eof && (i == nbytes-1);
      in_data = fr[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pops the expected result at each strobe
  always @(negedge clk) begin
    if (!rst && done && !finished) begin
      n_done++;
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R12 unexpected done: actual 1 expected 0");
      end else begin
        exp_t e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(t, "l3_kind", 64'(l3_kind), 64'(e.kind));
        chk(t, "l3_off", 64'(l3_off), 64'(e.off));
        chk("R11", "trunc", 64'(trunc), 64'(e.tr));
        chk("R3", "dst_mac", 64'(dst_mac), 64'(e.dst));
        chk("R3", "src_mac", 64'(src_mac), 64'(e.src));
        chk("R3", "first_type", 64'(first_type), 64'(e.ft));
        chk("R13", "last_type", 64'(last_type), 64'(e.lt));
        chk("R5", "vlan_tci", 64'(vlan_tci), 64'(e.tci));
        chk("R5", "vlan_hit", 64'(vlan_hit), 64'(e.vh));
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [47:0] snap_dst; logic [2:0] snap_kind; int snap_done;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "done", 64'(done), 64'(0));
    chk("R1", "l3_kind", 64'(l3_kind), 64'(0));
    chk("R1", "dst_mac", 64'(dst_mac), 64'(0));
    chk("R1", "last_type", 64'(last_type), 64'(0));
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R4 IPv4, trailing bytes must be ignored (R12)
    hdr(DA); p16(16'h0800); p8(8'h45); p8(8'h00); p8(8'h81); p8(8'h00); p8(8'h08); p8(8'h06);
    expect_res("R4", DA, 3'd1, 8'd14, 1'b0, 16'h0800, 16'h0800, 16'h0, 1'b0);
    send(fr.size(), 1'b1);

    // R5 VLAN then IPv6
    hdr(DA); p16(16'h8100); p16(16'h2ABC); p16(16'h86DD); p8(8'h60);
    expect_res("R5", DA, 3'd2, 8'd18, 1'b0, 16'h8100, 16'h86DD, 16'h2ABC, 1'b1);
    send(fr.size(), 1'b1);

    // R5 two VLAN tags then ARP, outermost control kept
    hdr(DB); p16(16'h8100); p16(16'h0111); p16(16'h8100); p16(16'h0222); p16(16'h0806);
    p8(8'h00); p8(8'h01);
    expect_res("R5", DB, 3'd3, 8'd22, 1'b0, 16'h8100, 16'h0806, 16'h0111, 1'b1);
    send(fr.size(), 1'b1);

    // R6 LLC/SNAP then IPv4
    hdr(DA); p16(16'h0040); p8(8'hAA); p8(8'hAA); p8(8'h03); p8(0); p8(0); p8(0);
    p16(16'h0800); p8(8'h45);
    expect_res("R6", DA, 3'd1, 8'd22, 1'b0, 16'h0040, 16'h0800, 16'h0, 1'b0);
    send(fr.size(), 1'b1);

    // R6 plain LLC
    hdr(DA); p16(16'h0030); p8(8'h42); p8(8'h42); p8(8'h03); p8(8'hEE);
    expect_res("R6", DA, 3'd4, 8'd17, 1'b0, 16'h0030, 16'h0030, 16'h0, 1'b0);
    send(fr.size(), 1'b1);

    // R7 length after SNAP refused
    hdr(DA); p16(16'h0040); p8(8'hAA); p8(8'hAA); p8(8'h03); p8(0); p8(0); p8(0);
    p16(16'h0030); p8(8'h00);
    expect_res("R7", DA, 3'd4, 8'd20, 1'b0, 16'h0040, 16'h0040, 16'h0, 1'b0);
    send(fr.size(), 1'b1);

    // R6 jumbo/SNAP then IPv6
    hdr(DA); p16(16'h8870); p8(8'hAA); p8(8'hAA); p8(8'h03); p8(0); p8(0); p8(0);
    p16(16'h86DD); p8(8'h60);
    expect_res("R6", DA, 3'd2, 8'd22, 1'b0, 16'h8870, 16'h86DD, 16'h0, 1'b0);
    send(fr.size(), 1'b1);

    // R8 unsupported after VLAN
    hdr(DA); p16(16'h8100); p16(16'h0005); p16(16'h88CC); p8(8'h00);
    expect_res("R8", DA, 3'd4, 8'd16, 1'b0, 16'h8100, 16'h8100, 16'h0005, 1'b1);
    send(fr.size(), 1'b1);

    // R8 unsupported first type
    hdr(DB); p16(16'h88CC); p8(8'h00);
    expect_res("R8", DB, 3'd4, 8'd12, 1'b0, 16'h88CC, 16'h0000, 16'h0, 1'b0);
    send(fr.size(), 1'b1);

    // R9 two labels, IPv4 payload
    hdr(DA); p16(16'h8847); p8(8'h00); p8(8'h01); p8(8'h00); p8(8'h40);
    p8(8'h00); p8(8'h02); p8(8'h01); p8(8'h40); p8(8'h45);
    expect_res("R9", DA, 3'd1, 8'd22, 1'b0, 16'h8847, 16'h8847, 16'h0, 1'b0);
    send(fr.size(), 1'b1);

    // R9 multicast label, IPv6 payload
    hdr(DA); p16(16'h8848); p8(8'h00); p8(8'h03); p8(8'h01); p8(8'h10); p8(8'h60);
    expect_res("R9", DA, 3'd2, 8'd18, 1'b0, 16'h8848, 16'h8848, 16'h0, 1'b0);
    send(fr.size(), 1'b1);

    // R9 unknown payload nibble
    hdr(DA); p16(16'h8847); p8(8'h00); p8(8'h03); p8(8'h01); p8(8'h10); p8(8'h00);
    expect_res("R9", DA, 3'd4, 8'd18, 1'b0, 16'h8847, 16'h8847, 16'h0, 1'b0);
    send(fr.size(), 1'b1);

    // R10 PPPoE protocol variants
    hdr(DA); p16(16'h8864); p8(8'h11); p8(0); p8(0); p8(8'h01); p8(0); p8(8'h40);
    p16(16'h0021); p8(8'h45);
    expect_res("R10", DA, 3'd1, 8'd22, 1'b0, 16'h8864, 16'h8864, 16'h0, 1'b0);
    send(fr.size(), 1'b1);

    hdr(DA); p16(16'h8864); p8(8'h11); p8(0); p8(0); p8(8'h01); p8(0); p8(8'h40);
    p16(16'h0057); p8(8'h60);
    expect_res("R10", DA, 3'd2, 8'd22, 1'b0, 16'h8864, 16'h8864, 16'h0, 1'b0);
    send(fr.size(), 1'b1);

    hdr(DA); p16(16'h8864); p8(8'h11); p8(0); p8(0); p8(8'h01); p8(0); p8(8'h40);
    p16(16'h0281); p8(8'h00); p8(8'h04); p8(8'h01); p8(8'h20); p8(8'h60);
    expect_res("R10", DA, 3'd2, 8'd26, 1'b0, 16'h8864, 16'h8864, 16'h0, 1'b0);
    send(fr.size(), 1'b1);

    hdr(DA); p16(16'h8864); p8(8'h11); p8(0); p8(0); p8(8'h01); p8(0); p8(8'h40);
    p16(16'hC021); p8(8'h00);
    expect_res("R10", DA, 3'd4, 8'd22, 1'b0, 16'h8864, 16'h8864, 16'h0, 1'b0);
    send(fr.size(), 1'b1);

    // R11 frame ends inside the walk
    hdr(DB); p16(16'h8100); p16(16'h0777);
    expect_res("R11", DB, 3'd0, 8'd16, 1'b1, 16'h8100, 16'h8100, 16'h0777, 1'b1);
    send(fr.size(), 1'b1);

    // R12 a new start byte abandons a partial frame
    hdr(DB); p16(16'h0800);
    send(10, 1'b0);
    hdr(DA); p16(16'h0806); p8(8'h00);
    expect_res("R12", DA, 3'd3, 8'd14, 1'b0, 16'h0806, 16'h0806, 16'h0, 1'b0);
    send(fr.size(), 1'b1);

    // R2 disabled frame leaves every output alone
    snap_dst = dst_mac; snap_kind = l3_kind; snap_done = n_done;
    cfg_depth = 4'd0;
    hdr(DB); p16(16'h86DD); p8(8'h60);
    send(fr.size(), 1'b1);
    chk("R2", "done count", 64'(n_done), 64'(snap_done));
    chk("R2", "dst_mac", 64'(dst_mac), 64'(snap_dst));
    chk("R2", "l3_kind", 64'(l3_kind), 64'(snap_kind));
    chk("R2", "last_type", 64'(last_type), 64'(16'h0806));
    cfg_depth = 4'd3;

    // R4 walking resumes once enabled
    hdr(DB); p16(16'h86DD); p8(8'h60);
    expect_res("R4", DB, 3'd2, 8'd14, 1'b0, 16'h86DD, 16'h86DD, 16'h0, 1'b0);
    send(fr.size(), 1'b1);

    repeat (5) @(negedge clk);
    chk("R4", "pending results", 64'(exp_q.size()), 64'(0));
    summary();
    $finish;
  end
endmodule